// File: doc/BRIEF.md
# Stack and program counter sequencer

This block owns a processor's program counter and stack pointer and runs the byte-wide memory cycles behind the stack-related operations. These are pushing and popping a register pair, subroutine call and return (both unconditional and guarded by a condition), restart to a fixed vector, loading the program counter or stack pointer from a 16-bit operand, and swapping a 16-bit operand with the word on top of the stack. A decoder outside the block supplies a command, a 16-bit operand and a condition-true bit. The block then drives a single-port byte memory whose read data returns one cycle after the read address.

The program counter is taken to already hold the address of the instruction after the current one, as fetch logic would leave it. A call or restart pushes that value. A condition that is false leaves the counter where it is. Commands are accepted only while `idle_o` is high. A one-cycle `done_o` pulse marks each completion. A popped word, or the old top-of-stack word from a swap, appears on `result_o` and is held there until it is replaced.

Top module: `stk_seq`

## Requirements
- R1: Command code 0 (push) writes operand bits 15:8 to address SP-1 and then operand bits 7:0 to address SP-2, in consecutive cycles, and leaves SP lowered by 2.
- R2: Command code 1 (pop) reads address SP and then SP+1 in consecutive cycles. It returns {byte at SP+1, byte at SP} on `result_o` and leaves SP raised by 2.
- R3: Command code 2 (call), and code 3 (conditional call) with `cond_i` high, push the current PC exactly as R1 pushes a word, then load PC with the operand.
- R4: Command code 4 (return), and code 5 (conditional return) with `cond_i` high, pop a word exactly as R2 does and load PC with it.
- R5: Command code 6 (restart) pushes the current PC as in R1 and then loads PC with operand bits 2:0 times 8 (0x0000 to 0x0038). All other operand bits are ignored.
- R6: Command code 7 copies the operand into PC, and code 8 copies it into SP. Neither makes a memory access. Outside this command and the stack steps, SP does not change while idle.
- R7: Command code 9 (swap) reads SP and SP+1, then writes operand bits 7:0 to SP and operand bits 15:8 to SP+1. The old word {byte at SP+1, byte at SP} goes to `result_o`, and SP is unchanged.
- R8: Codes 3 and 5 with `cond_i` low make no memory access, leave PC and SP unchanged, and complete with `done_o` in the cycle after acceptance.
- R9: At most one memory access happens per cycle; `mem_we_o` and `mem_re_o` are never high together.
- R10: `done_o` is high for exactly one cycle per command, in a cycle where `idle_o` is high. A command presented while `idle_o` is low is ignored.
- R11: SP arithmetic wraps modulo 65536 in both directions.
- R12: During reset PC equals RESET_PC and SP equals RESET_SP, `idle_o` is high, and `done_o`, `mem_we_o` and `mem_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; taken only while idle |
| cmd_i | input | 4 | Command code (see requirements) |
| operand_i | input | 16 | Pair data, target address, restart number or HL value |
| cond_i | input | 1 | Condition true, for the conditional call and return |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read |
| idle_o | output | 1 | Ready to accept a command |
| done_o | output | 1 | One-cycle completion strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| result_o | output | 16 | Last popped or swapped-out word |

## Verification
The bench builds the block with RESET_PC = 0x0100 and RESET_SP = 0x0001. The first push after reset therefore crosses from 0x0000 down to 0xFFFF with no setup command, and the wrap on decrement is tested at once. A later pop from 0xFFFF reads back across the same boundary and checks the wrap on increment. The reset values differ from zero, so a design that ignores the parameters shows up in the first check.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  typedef enum logic [3:0] {
    CMD_PUSH     = 4'd0,
    CMD_POP      = 4'd1,
    CMD_CALL     = 4'd2,
    CMD_CALL_IF  = 4'd3,
    CMD_RET      = 4'd4,
    CMD_RET_IF   = 4'd5,
    CMD_RST      = 4'd6,
    CMD_LD_PC    = 4'd7,
    CMD_LD_SP    = 4'd8,
    CMD_SWAP_TOP = 4'd9
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_END,
    ST_XR_LO,
    ST_XR_HI,
    ST_XW_LO,
    ST_XW_HI
  } state_e;

endpackage

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
  import stk_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_valid_i,
  input  cmd_e   cmd_i,
  input  logic   cond_i,
  output state_e state_o,
  output cmd_e   cmd_q_o,
  output logic   accept_o,
  output logic   done_o
);

  state_e state_q, state_d;
  cmd_e   cmd_q;
  logic   done_q, done_d;

  assign accept_o = (state_q == ST_IDLE) && cmd_valid_i;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          unique case (cmd_i)
            CMD_PUSH, CMD_CALL, CMD_RST: state_d = ST_WR_HI;
            CMD_CALL_IF:                 state_d = cond_i ? ST_WR_HI : ST_IDLE;
            CMD_POP, CMD_RET:            state_d = ST_RD_LO;
            CMD_RET_IF:                  state_d = cond_i ? ST_RD_LO : ST_IDLE;
            CMD_SWAP_TOP:                state_d = ST_XR_LO;
            default:                     state_d = ST_IDLE;
          endcase
          done_d = (state_d == ST_IDLE);
        end
      end
      ST_WR_HI:  state_d = ST_WR_LO;
      ST_WR_LO:  begin state_d = ST_IDLE; done_d = 1'b1; end
      ST_RD_LO:  state_d = ST_RD_HI;
      ST_RD_HI:  state_d = ST_RD_END;
      ST_RD_END: begin state_d = ST_IDLE; done_d = 1'b1; end
      ST_XR_LO:  state_d = ST_XR_HI;
      ST_XR_HI:  state_d = ST_XW_LO;
      ST_XW_LO:  state_d = ST_XW_HI;
      ST_XW_HI:  begin state_d = ST_IDLE; done_d = 1'b1; end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_PUSH;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept_o) cmd_q <= cmd_i;
    end
  end

  assign state_o = state_q;
  assign cmd_q_o = cmd_q;
  assign done_o  = done_q;

endmodule

// File: rtl/stk_seq_ptrs.sv
module stk_seq_ptrs
  import stk_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] RESET_SP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  logic              accept_i,
  input  cmd_e              cmd_i,
  input  cmd_e              cmd_q_i,
  input  logic [ADDR_W-1:0] operand_i,
  input  logic [ADDR_W-1:0] popped_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] opnd_o,
  output logic [ADDR_W-1:0] push_word_o
);

  localparam int unsigned VEC_LG2 = 3;
  localparam int unsigned VEC_N_W = 3;

  logic [ADDR_W-1:0] pc_q, sp_q, opnd_q, rst_tgt;
  logic              is_call, is_ret;

  assign is_call = (cmd_q_i == CMD_CALL) || (cmd_q_i == CMD_CALL_IF);
  assign is_ret  = (cmd_q_i == CMD_RET)  || (cmd_q_i == CMD_RET_IF);

  always_comb begin
    rst_tgt = '0;
    rst_tgt[VEC_LG2 +: VEC_N_W] = opnd_q[VEC_N_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      sp_q   <= RESET_SP;
      opnd_q <= '0;
    end else begin
      if (accept_i) begin
        opnd_q <= operand_i;
        if (cmd_i == CMD_LD_PC) pc_q <= operand_i;
        if (cmd_i == CMD_LD_SP) sp_q <= operand_i;
      end
      unique case (state_i)
        ST_WR_HI: sp_q <= sp_q - 1'b1;
        ST_WR_LO: begin
          sp_q <= sp_q - 1'b1;
          if (is_call)                  pc_q <= opnd_q;
          else if (cmd_q_i == CMD_RST)  pc_q <= rst_tgt;
        end
        ST_RD_LO, ST_RD_HI: sp_q <= sp_q + 1'b1;
        ST_RD_END: if (is_ret) pc_q <= popped_i;
        default: ;
      endcase
    end
  end

  assign pc_o        = pc_q;
  assign sp_o        = sp_q;
  assign opnd_o      = opnd_q;
  assign push_word_o = (cmd_q_i == CMD_PUSH) ? opnd_q : pc_q;

endmodule

// File: rtl/stk_seq_mem.sv
module stk_seq_mem
  import stk_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] push_word_i,
  input  logic [ADDR_W-1:0] opnd_i,
  input  logic [ADDR_W/2-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W/2-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] popped_o,
  output logic [ADDR_W-1:0] result_o
);

  localparam int unsigned BYTE_W = ADDR_W / 2;

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [ADDR_W-1:0] result_q, sp_inc, sp_dec;

  assign sp_inc   = sp_i + 1'b1;
  assign sp_dec   = sp_i - 1'b1;
  assign popped_o = {rdata_i, lo_q};

  always_comb begin
    addr_o  = sp_i;
    wdata_o = '0;
    we_o    = 1'b0;
    re_o    = 1'b0;
    unique case (state_i)
      ST_WR_HI: begin addr_o = sp_dec; wdata_o = push_word_i[BYTE_W +: BYTE_W]; we_o = 1'b1; end
      ST_WR_LO: begin addr_o = sp_dec; wdata_o = push_word_i[0 +: BYTE_W];      we_o = 1'b1; end
      ST_RD_LO, ST_RD_HI, ST_XR_LO: re_o = 1'b1;
      ST_XR_HI: begin addr_o = sp_inc; re_o = 1'b1; end
      ST_XW_LO: begin wdata_o = opnd_i[0 +: BYTE_W]; we_o = 1'b1; end
      ST_XW_HI: begin addr_o = sp_inc; wdata_o = opnd_i[BYTE_W +: BYTE_W]; we_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      result_q <= '0;
    end else begin
      unique case (state_i)
        ST_RD_HI, ST_XR_HI: lo_q <= rdata_i;
        ST_RD_END:          result_q <= popped_o;
        ST_XW_LO:           hi_q <= rdata_i;
        ST_XW_HI:           result_q <= {hi_q, lo_q};
        default: ;
      endcase
    end
  end

  assign result_o = result_q;

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] RESET_SP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] operand_i,
  input  logic              cond_i,
  input  logic [ADDR_W/2-1:0] mem_rdata_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W/2-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] result_o
);

  state_e            state;
  cmd_e              cmd_in, cmd_q;
  logic              accept;
  logic [ADDR_W-1:0] opnd_q, push_word, popped;

  assign cmd_in = cmd_e'(cmd_i);
  assign idle_o = (state == ST_IDLE);

  stk_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_in),
    .cond_i     (cond_i),
    .state_o    (state),
    .cmd_q_o    (cmd_q),
    .accept_o   (accept),
    .done_o     (done_o)
  );

  stk_seq_ptrs #(
    .ADDR_W  (ADDR_W),
    .RESET_PC(RESET_PC),
    .RESET_SP(RESET_SP)
  ) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .accept_i   (accept),
    .cmd_i      (cmd_in),
    .cmd_q_i    (cmd_q),
    .operand_i  (operand_i),
    .popped_i   (popped),
    .pc_o       (pc_o),
    .sp_o       (sp_o),
    .opnd_o     (opnd_q),
    .push_word_o(push_word)
  );

  stk_seq_mem #(
    .ADDR_W(ADDR_W)
  ) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .sp_i       (sp_o),
    .push_word_i(push_word),
    .opnd_i     (opnd_q),
    .rdata_i    (mem_rdata_i),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o),
    .we_o       (mem_we_o),
    .re_o       (mem_re_o),
    .popped_o   (popped),
    .result_o   (result_o)
  );

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_i,
  input logic              idle_o,
  input logic              done_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] sp_o
);

  localparam logic [3:0] LD_SP_CODE = 4'd8;

  AST_NO_DUAL_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !(mem_we_o || mem_re_o)); // R8

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> idle_o); // R10

  AST_READ_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))); // R2

  AST_SP_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !(cmd_valid_i && cmd_i == LD_SP_CODE)) |=> $stable(sp_o)); // R6

endmodule

bind stk_seq stk_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_i      (cmd_i),
  .idle_o     (idle_o),
  .done_o     (done_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .sp_o       (sp_o)
);

// File: tb/stk_seq_tb.sv
module stk_seq_tb;
  import stk_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [15:0] operand = 16'h0;
  logic        cond = 1'b0;
  logic [7:0]  rdata = 8'h0;
  logic        idle, done, we, re;
  logic [15:0] addr, pc, sp, result;
  logic [7:0]  wdata;

  always #5 clk = ~clk;

  stk_seq #(
    .ADDR_W  (16),
    .RESET_PC(16'h0100),
    .RESET_SP(16'h0001)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .operand_i(operand), .cond_i(cond), .mem_rdata_i(rdata),
    .idle_o(idle), .done_o(done), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_re_o(re), .pc_o(pc), .sp_o(sp), .result_o(result)
  );

  typedef struct {
    bit          wr;
    logic [15:0] a;
    logic [7:0]  d;
    string       req;
  } acc_t;

  acc_t        exp_q[$];
  logic [7:0]  mem [int];
  int          checks = 0;
  int          fails = 0;
  logic [15:0] e_pc, e_sp, w;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (we) mem[int'(addr)] = wdata;
    if (re) rdata <= rd(addr);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (we || re)) begin
      chk("R9", 32'(we & re), 32'(0));
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected access act=%h exp=none", {we, addr, wdata});
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(e.req, {7'd0, we, addr, (we ? wdata : 8'h00)},
                   {7'd0, e.wr, e.a, (e.wr ? e.d : 8'h00)});
      end
    end
  end

  task automatic exp_wr(input logic [15:0] a, input logic [7:0] d, input string req);
    acc_t e;
    e.wr = 1'b1; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic exp_rd(input logic [15:0] a, input string req);
    acc_t e;
    e.wr = 1'b0; e.a = a; e.d = 8'h00; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic exp_push(input logic [15:0] word, input string req);
    exp_wr(16'(e_sp - 16'd1), word[15:8], req);
    exp_wr(16'(e_sp - 16'd2), word[7:0], req);
    e_sp = 16'(e_sp - 16'd2);
  endtask

  task automatic exp_pop(output logic [15:0] word, input string req);
    word = {rd(16'(e_sp + 16'd1)), rd(e_sp)};
    exp_rd(e_sp, req);
    exp_rd(16'(e_sp + 16'd1), req);
    e_sp = 16'(e_sp + 16'd2);
  endtask

  task automatic run(input cmd_e c, input logic [15:0] op, input logic cd, input string req);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; operand = op; cond = cd;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(done), 32'(1));
    chk(req, 32'(pc), 32'(e_pc));
    chk(req, 32'(sp), 32'(e_sp));
    chk(req, 32'(exp_q.size()), 32'(0));
    @(negedge clk);
    chk("R10", 32'(done), 32'(0));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", 32'(pc), 32'h0100);
    chk("R12", 32'(sp), 32'h0001);
    chk("R12", 32'(idle), 32'(1));
    chk("R12", 32'({done, we, re}), 32'(0));
    rst_n = 1'b1;
    e_pc = 16'h0100;
    e_sp = 16'h0001;

    // R1 push, crossing zero (R11)
    exp_push(16'hA55A, "R1");
    run(CMD_PUSH, 16'hA55A, 1'b0, "R1");
    chk("R11", 32'(sp), 32'h0000_FFFF);

    // R6 loads
    e_sp = 16'h2000;
    run(CMD_LD_SP, 16'h2000, 1'b0, "R6");
    e_pc = 16'h1234;
    run(CMD_LD_PC, 16'h1234, 1'b0, "R6");

    exp_push(16'hBEEF, "R1");
    run(CMD_PUSH, 16'hBEEF, 1'b0, "R1");

    // R2 pop
    exp_pop(w, "R2");
    run(CMD_POP, 16'h0000, 1'b0, "R2");
    chk("R2", 32'(result), 32'h0000_BEEF);

    // R3 call
    exp_push(e_pc, "R3");
    e_pc = 16'h4000;
    run(CMD_CALL, 16'h4000, 1'b0, "R3");

    // R5 restart 5
    exp_push(e_pc, "R5");
    e_pc = 16'h0028;
    run(CMD_RST, 16'h0005, 1'b0, "R5");

    // R4 return
    exp_pop(w, "R4");
    e_pc = w;
    run(CMD_RET, 16'h0000, 1'b0, "R4");
    chk("R4", 32'(pc), 32'h0000_4000);

    // R8 conditional forms with false condition
    run(CMD_CALL_IF, 16'h7777, 1'b0, "R8");
    run(CMD_RET_IF, 16'h0000, 1'b0, "R8");

    // R7 swap with top of stack
    w = {rd(16'(e_sp + 16'd1)), rd(e_sp)};
    exp_rd(e_sp, "R7");
    exp_rd(16'(e_sp + 16'd1), "R7");
    exp_wr(e_sp, 8'hFE, "R7");
    exp_wr(16'(e_sp + 16'd1), 8'hCA, "R7");
    run(CMD_SWAP_TOP, 16'hCAFE, 1'b0, "R7");
    chk("R7", 32'(result), 32'(w));
    chk("R7", 32'(result), 32'h0000_1234);

    // R4 conditional return taken
    exp_pop(w, "R4");
    e_pc = w;
    run(CMD_RET_IF, 16'h0000, 1'b1, "R4");
    chk("R4", 32'(pc), 32'h0000_CAFE);

    // R3 conditional call taken
    exp_push(e_pc, "R3");
    e_pc = 16'h0040;
    run(CMD_CALL_IF, 16'h0040, 1'b1, "R3");

    // R10 command while busy is ignored
    exp_push(16'h1357, "R10");
    @(negedge clk);
    cmd_valid = 1'b1; cmd = CMD_PUSH; operand = 16'h1357;
    @(negedge clk);
    cmd = CMD_LD_SP; operand = 16'h5555;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R10", 32'(done), 32'(1));
    chk("R10", 32'(sp), 32'(e_sp));
    @(negedge clk);
    chk("R10", 32'(done), 32'(0));
    chk("R10", 32'(sp), 32'(e_sp));

    // R5 restart 7 and restart 0 with high operand bits set
    exp_push(e_pc, "R5");
    e_pc = 16'h0038;
    run(CMD_RST, 16'h0007, 1'b0, "R5");
    exp_push(e_pc, "R5");
    e_pc = 16'h0000;
    run(CMD_RST, 16'hFFF8, 1'b0, "R5");

    // R11 pop across the top of the address space
    e_sp = 16'hFFFF;
    run(CMD_LD_SP, 16'hFFFF, 1'b0, "R6");
    exp_pop(w, "R11");
    run(CMD_POP, 16'h0000, 1'b0, "R11");
    chk("R11", 32'(result), 32'h0000_A55A);
    chk("R11", 32'(sp), 32'h0000_0001);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule